// File: doc/BRIEF.md
# Qualified Edge Condition Detector

This block watches a pair of serial interface lines: a qualifier line and a clocked line. It reports two events. A *falling condition* is a high-to-low transition of the clocked line while the qualifier line is high. A *rising condition* is a low-to-high transition of the clocked line while the qualifier line is high. Each condition has its own sticky status flag and its own interrupt pulse. Software polls or clears each flag through a small register port. Each flag has its own address, and any write to that address clears the flag.

Both lines pass through a multi-flop synchronizer. A three-state level tracker then remembers the previous synchronized level of the clocked line. Its states are `LVL_SEED`, `LVL_LOW` and `LVL_HIGH`. After reset the tracker sits in `LVL_SEED` until the synchronizer holds real samples, and then moves to `LVL_LOW` or `LVL_HIGH` to match the line. After that it moves from `LVL_LOW` to `LVL_HIGH` on a rise and from `LVL_HIGH` to `LVL_LOW` on a fall. The tracker follows the line whether or not the block is enabled. The enable input only gates whether a detected condition is recorded. The receive/transmit mode input has no effect on detection.

Top module: `edge_cond_detector`

## Requirements
- R1: A falling condition is reported when the synchronized clocked line goes from 1 to 0 while the synchronized qualifier line is 1. No falling condition is reported when the qualifier is 0.
- R2: A rising condition is reported when the synchronized clocked line goes from 0 to 1 while the synchronized qualifier line is 1. No rising condition is reported when the qualifier is 0.
- R3: A condition sets its flag and raises its interrupt only while `enable` is 1. Conditions that occur while `enable` is 0 leave no trace.
- R4: `mode_tx` (0 = receive, 1 = transmit) does not change detection. Both conditions are reported in both modes.
- R5: Each flag stays set until reset or until a write (`reg_wr`=1) to its own address. The falling flag is at address 0 and the rising flag is at address 1, whatever the data. A write to the other address, or to any unused address, leaves a flag unchanged.
- R6: A read of address 0 or address 1 returns the flag in bit 0 and zero in every other bit. A read of any other address returns zero.
- R7: `irq_fall` and `irq_rise` are separate lines. Each is a pulse one clock long. The pulse is high in the third clock edge after the input change: two synchronizer stages, then one register.
- R8: When a clearing write and a new detection of the same condition meet in one cycle, the flag ends set.
- R9: No condition is reported for a line level that was already present when reset was released or when `enable` was raised.
- R10: Reset clears both flags and both interrupt lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Interface enable; gates recording of conditions |
| mode_tx | input | 1 | 0 receive, 1 transmit; does not affect detection |
| line_qual | input | 1 | Asynchronous qualifier line |
| line_clk | input | 1 | Asynchronous clocked line whose edges are watched |
| reg_addr | input | ADDR_W (4) | Register address for read and write |
| reg_wr | input | 1 | Write strobe; clears the addressed flag |
| reg_rdata | output | DATA_W (8) | Combinational read data for `reg_addr` |
| irq_fall | output | 1 | One-cycle pulse on a recorded falling condition |
| irq_rise | output | 1 | One-cycle pulse on a recorded rising condition |

## Verification
The bench goes after these corner cases:

- A clocked-line edge while the qualifier is low. A detector that ignored the qualifier would pulse there.
- Raising `enable` while the clocked line is already high, and releasing reset with both lines high. A tracker that froze while disabled, or that started from a fixed level, would report a false edge in these cases.
- A clearing write that lands in the same cycle as a fresh detection. A clear-priority flag would lose that event.
- A write to the neighbouring address, and a write to an unused address. Sloppy address decoding would wipe the wrong flag.
- Edges in transmit mode, and edges while disabled. These show that only `enable` gates recording.

// File: rtl/ecd_pkg.sv
package ecd_pkg;

    typedef enum logic [1:0] {
        LVL_SEED = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_HIGH = 2'd2
    } lvl_state_e;

    typedef struct packed {
        logic fall;
        logic rise;
    } cond_pair_t;

endpackage

// File: rtl/ecd_sync.sv
module ecd_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/ecd_edge_fsm.sv
module ecd_edge_fsm
    import ecd_pkg::*;
#(
    parameter int unsigned SETTLE = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       qual_i,
    input  logic       line_i,
    output cond_pair_t det_o
);

    localparam int unsigned CNT_W = $clog2(SETTLE + 1);
    localparam logic [CNT_W-1:0] SETTLE_C = CNT_W'(SETTLE);

    lvl_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_SEED;
        else        state_q <= state_d;
    end

    // settle counter: waits until the synchronizer holds real samples
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                    cnt_q <= '0;
        else if (state_q == LVL_SEED && cnt_q != SETTLE_C) cnt_q <= cnt_q + 1'b1;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_SEED: if (cnt_q == SETTLE_C) state_d = line_i ? LVL_HIGH : LVL_LOW;
            LVL_LOW:  if (line_i)            state_d = LVL_HIGH;
            LVL_HIGH: if (!line_i)           state_d = LVL_LOW;
            default:                         state_d = LVL_SEED;
        endcase
    end

    // outputs
    always_comb begin
        det_o = '0;
        unique case (state_q)
            LVL_SEED: det_o = '0;
            LVL_LOW:  det_o.rise = line_i & qual_i;
            LVL_HIGH: det_o.fall = ~line_i & qual_i;
            default:  det_o = '0;
        endcase
    end

    // R9
    seed_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LVL_SEED && cnt_q == SETTLE_C) |=> (state_q != LVL_SEED));

endmodule

// File: rtl/ecd_flag.sv
module ecd_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o,
    output logic irq_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
            irq_o  <= 1'b0;
        end else begin
            irq_o <= set_i;
            if (set_i)      flag_o <= 1'b1;
            else if (clr_i) flag_o <= 1'b0;
        end
    end

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> (flag_o && irq_o));

    // R5
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);

    // R5
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);

endmodule

// File: rtl/edge_cond_detector.sv
module edge_cond_detector
    import ecd_pkg::*;
#(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FALL_ADDR   = 0,
    parameter int unsigned RISE_ADDR   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              mode_tx,
    input  logic              line_qual,
    input  logic              line_clk,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_fall,
    output logic              irq_rise
);

    localparam int unsigned LINES = 2;
    localparam logic [ADDR_W-1:0] FALL_SEL = ADDR_W'(FALL_ADDR);
    localparam logic [ADDR_W-1:0] RISE_SEL = ADDR_W'(RISE_ADDR);

    logic [LINES-1:0] lines_sync;
    cond_pair_t       det;
    logic             flag_fall, flag_rise;
    logic             clr_fall, clr_rise;

    ecd_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({line_qual, line_clk}),
        .sync_o  (lines_sync)
    );

    ecd_edge_fsm #(.SETTLE(SYNC_STAGES)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .qual_i (lines_sync[1]),
        .line_i (lines_sync[0]),
        .det_o  (det)
    );

    assign clr_fall = reg_wr && (reg_addr == FALL_SEL);
    assign clr_rise = reg_wr && (reg_addr == RISE_SEL);

    ecd_flag u_flag_fall (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (det.fall & enable),
        .clr_i  (clr_fall),
        .flag_o (flag_fall),
        .irq_o  (irq_fall)
    );

    ecd_flag u_flag_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (det.rise & enable),
        .clr_i  (clr_rise),
        .flag_o (flag_rise),
        .irq_o  (irq_rise)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == FALL_SEL)      reg_rdata[0] = flag_fall;
        else if (reg_addr == RISE_SEL) reg_rdata[0] = flag_rise;
    end

    // R7
    irq_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_fall, irq_rise}));

    // R7
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_fall || irq_rise) |=> !(irq_fall && $past(irq_fall)) && !(irq_rise && $past(irq_rise)));

    // R3
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_fall) || $rose(irq_rise) |-> $past(enable));

    // R4
    tx_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (det.fall && enable && mode_tx) |=> irq_fall);

    // R6
    rdata_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:1] == '0);

endmodule

// File: tb/edge_cond_detector_bench.sv
module edge_cond_detector_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       mode_tx = 1'b0;
    logic       line_qual = 1'b0;
    logic       line_clk = 1'b0;
    logic [3:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_rdata;
    logic       irq_fall, irq_rise;

    always #10 clk = ~clk;

    edge_cond_detector u_edge_cond_detector (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode_tx(mode_tx),
        .line_qual(line_qual), .line_clk(line_clk),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rdata(reg_rdata),
        .irq_fall(irq_fall), .irq_rise(irq_rise)
    );

    typedef struct {
        int due;
        bit f;
        bit r;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    bit   m_fall = 0, m_rise = 0;
    bit   prev_clk_line = 0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, expv, $time);
        end
    endtask

    // monitor: compares irq lines against queued expectations
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
                exp_t e;
                e = exp_q.pop_front();
                check(irq_fall == e.f, {e.req, " irq_fall"}, irq_fall, e.f);
                check(irq_rise == e.r, {e.req, " irq_rise"}, irq_rise, e.r);
            end else if (irq_fall || irq_rise) begin
                check(1'b0, "R7 unexpected irq", {irq_fall, irq_rise}, 0);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // driver: changes the lines and predicts the outcome
    task automatic drive(input bit q, input bit c, input string req);
        bit f, r;
        f = enable && prev_clk_line && !c && q;
        r = enable && !prev_clk_line && c && q;
        line_qual = q;
        line_clk  = c;
        prev_clk_line = c;
        if (f || r) begin
            exp_q.push_back('{cyc + 4, f, r, req});
            if (f) m_fall = 1;
            if (r) m_rise = 1;
        end
        tick(6);
    endtask

    task automatic read_chk(input logic [3:0] a, input int expv, input string req);
        reg_addr = a;
        #1;
        check(reg_rdata == 8'(expv), req, reg_rdata, expv);
    endtask

    task automatic write_reg(input logic [3:0] a);
        reg_addr = a;
        reg_wr = 1'b1;
        tick(1);
        reg_wr = 1'b0;
        if (a == 4'd0) m_fall = 0;
        if (a == 4'd1) m_rise = 0;
        tick(1);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        // R10 reset state
        tick(2);
        check(irq_fall == 0 && irq_rise == 0, "R10 irq in reset", {irq_fall, irq_rise}, 0);
        read_chk(4'd0, 0, "R10 fall flag in reset");
        read_chk(4'd1, 0, "R10 rise flag in reset");
        rst_n = 1'b1;
        tick(5);
        enable = 1'b1;

        // R1 falling condition with qualifier high
        drive(1, 1, "R2 rise");
        drive(1, 0, "R1 fall");
        read_chk(4'd0, 1, "R1 fall flag set");
        read_chk(4'd1, 1, "R2 rise flag set");
        read_chk(4'd5, 0, "R6 unused address reads zero");

        // R5 clearing one flag leaves the other
        write_reg(4'd0);
        read_chk(4'd0, 0, "R5 fall flag cleared");
        read_chk(4'd1, 1, "R5 rise flag kept");
        write_reg(4'd7);
        read_chk(4'd1, 1, "R5 unused write ignored");
        write_reg(4'd1);
        read_chk(4'd1, 0, "R5 rise flag cleared");

        // R1 R2 qualifier low: nothing
        drive(0, 1, "R2 qual low");
        drive(0, 0, "R1 qual low");
        read_chk(4'd0, 0, "R1 no flag without qualifier");
        read_chk(4'd1, 0, "R2 no flag without qualifier");

        // R3 disabled: edges leave no trace
        enable = 1'b0;
        drive(1, 1, "R3 disabled");
        drive(1, 0, "R3 disabled");
        drive(1, 1, "R3 disabled");
        read_chk(4'd0, 0, "R3 fall flag stays clear");
        read_chk(4'd1, 0, "R3 rise flag stays clear");
        // R9 enabling with the line already high
        enable = 1'b1;
        tick(6);
        read_chk(4'd1, 0, "R9 no rise on enable");

        // R4 transmit mode
        mode_tx = 1'b1;
        drive(1, 0, "R4 fall in tx");
        drive(1, 1, "R4 rise in tx");
        read_chk(4'd0, 1, "R4 fall flag in tx");
        read_chk(4'd1, 1, "R4 rise flag in tx");
        write_reg(4'd0);
        write_reg(4'd1);
        mode_tx = 1'b0;

        // R8 clear and detect in the same cycle
        line_qual = 1'b1;
        line_clk = 1'b0;
        prev_clk_line = 0;
        exp_q.push_back('{cyc + 4, 1, 0, "R8 fall"});
        tick(2);
        reg_addr = 4'd0;
        reg_wr = 1'b1;
        tick(1);
        reg_wr = 1'b0;
        tick(4);
        read_chk(4'd0, 1, "R8 set wins over clear");

        // R10 reset with lines high, R9 no false edge after release
        rst_n = 1'b0;
        tick(1);
        line_clk = 1'b1;
        prev_clk_line = 1;
        read_chk(4'd0, 0, "R10 reset clears fall flag");
        tick(2);
        rst_n = 1'b1;
        tick(8);
        read_chk(4'd1, 0, "R9 no rise after reset release");
        drive(1, 0, "R1 fall after reset");
        read_chk(4'd0, 1, "R1 fall flag after reset");

        tick(4);
        check(exp_q.size() == 0, "R7 all expected pulses seen", exp_q.size(), 0);
        finish_run();
    end

endmodule